// File: doc/BRIEF.md
# PWM Output Polarity and Fault Stage

This block is the last stage between an eight-channel PWM timer and its pins. Each channel delivers a raw level where 1 means "active" and 0 means "inactive". The block turns that level into a pin level through a per-channel polarity bit. Polarity 0 makes a channel active-high, and polarity 1 makes it active-low.

When fault control is enabled and the fault-detected input is high, every pin is forced to its safe level in the same cycle. The safe level is the channel's inactive level, which equals its polarity bit. The override lifts as soon as either the fault input or the fault-control enable drops.

The polarity bits sit in one 8-bit register, with bit n belonging to channel n. Software may always read the register. A write changes the register only while the write-protect-disable input is high; otherwise the write is dropped without any indication. The read data is registered.

Top module: `pwm_pol_stage`

## Requirements
- R1: After reset every polarity bit is 0, so each pin follows its raw level and a read returns 8'h00.
- R2: A channel whose polarity bit is 0 drives its pin equal to its raw level while no fault override applies.
- R3: A channel whose polarity bit is 1 drives its pin to the inverse of its raw level while no fault override applies.
- R4: While fault_ctl_en and fault_det are both 1, pin n equals polarity bit n, in the same cycle the inputs assert and whatever the raw levels.
- R5: The override releases with no delay when either fault_det or fault_ctl_en returns to 0, and the pins again follow raw XOR polarity.
- R6: A write (reg_wr = 1) made while wp_dis = 1 loads reg_wdata into the polarity register at that clock edge, so it shows at the pins from the following cycle. Bit n of reg_wdata sets channel n.
- R7: A write made while wp_dis = 0 leaves the polarity register unchanged. The pins and later reads still show the old value.
- R8: A read (reg_rd = 1) returns the stored polarity bits on reg_rdata one clock after the request, whatever the value of wp_dis. reg_rdata holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Polarity register write strobe |
| reg_wdata | input | 8 | Write data, bit n for channel n |
| reg_rd | input | 1 | Polarity register read strobe |
| reg_rdata | output | 8 | Registered read data |
| wp_dis | input | 1 | Write-protect disable; writes take effect only when 1 |
| fault_ctl_en | input | 1 | Fault control enable |
| fault_det | input | 1 | Fault detected |
| pwm_raw | input | 8 | Raw active(1)/inactive(0) level per channel |
| pwm_pin | output | 8 | Pin level per channel |

## Verification
The pin path and the fault override have no register, so the bench changes pwm_raw, fault_ctl_en and fault_det just after a falling edge and checks pwm_pin 2 ns later, before any rising edge. A polarity write takes effect at the next rising edge. The bench checks it at the falling edge after that, both on the pins and through a read. A read strobe raised at a falling edge is captured at the next rising edge, so reg_rdata is compared one full cycle after the strobe. The bench steps through all 256 polarity values. For each one it sweeps all 256 raw patterns and varies the fault inputs as it goes.

// File: rtl/pwm_pol_pkg.sv
package pwm_pol_pkg;
  localparam int unsigned POL_NCH = 8;
  typedef logic [POL_NCH-1:0] pol_vec_t;
endpackage

// File: rtl/pwm_pol_reg.sv
module pwm_pol_reg #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [NCH-1:0] wdata,
  input  logic           rd,
  input  logic           wp_dis,
  output logic [NCH-1:0] pol_q,
  output logic [NCH-1:0] rdata
);
  logic wr_ok;
  assign wr_ok = wr & wp_dis;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q <= '0;
      rdata <= '0;
    end else begin
      if (wr_ok) pol_q <= wdata;
      if (rd) rdata <= pol_q;
    end
  end

  // R6
  wp_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && wp_dis) |=> (pol_q == $past(wdata)));
  // R7
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !wp_dis) |=> $stable(pol_q));
  // R8
  rd_data_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> (rdata == $past(pol_q)));
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/pwm_pol_fault_gate.sv
module pwm_pol_fault_gate (
  input  logic fault_ctl_en,
  input  logic fault_det,
  output logic force_safe
);
  assign force_safe = fault_ctl_en & fault_det;
endmodule

// File: rtl/pwm_pol_chan.sv
module pwm_pol_chan (
  input  logic raw,
  input  logic pol,
  input  logic force_safe,
  output logic pin
);
  always_comb begin
    if (force_safe) pin = pol;
    else            pin = raw ^ pol;
  end
endmodule

// File: rtl/pwm_pol_stage.sv
module pwm_pol_stage
  import pwm_pol_pkg::*;
#(
  parameter int unsigned NCH = POL_NCH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic [NCH-1:0] reg_wdata,
  input  logic           reg_rd,
  output logic [NCH-1:0] reg_rdata,
  input  logic           wp_dis,
  input  logic           fault_ctl_en,
  input  logic           fault_det,
  input  logic [NCH-1:0] pwm_raw,
  output logic [NCH-1:0] pwm_pin
);
  logic [NCH-1:0] pol_q;
  logic           force_safe;

  pwm_pol_reg #(.NCH(NCH)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .rd     (reg_rd),
    .wp_dis (wp_dis),
    .pol_q  (pol_q),
    .rdata  (reg_rdata)
  );

  pwm_pol_fault_gate u_gate (
    .fault_ctl_en (fault_ctl_en),
    .fault_det    (fault_det),
    .force_safe   (force_safe)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    pwm_pol_chan u_chan (
      .raw        (pwm_raw[n]),
      .pol        (pol_q[n]),
      .force_safe (force_safe),
      .pin        (pwm_pin[n])
    );
  end

  // R4
  fault_safe_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_ctl_en && fault_det) |-> (pwm_pin == pol_q));
  // R2 R3 R5
  normal_path_chk: assert property (@(posedge clk) disable iff (rst)
    !(fault_ctl_en && fault_det) |-> (pwm_pin == (pwm_raw ^ pol_q)));
endmodule

// File: tb/pwm_pol_stage_bench.sv
module pwm_pol_stage_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       wp_dis = 1'b0;
  logic       fault_ctl_en = 1'b0;
  logic       fault_det = 1'b0;
  logic [7:0] pwm_raw = '0;
  logic [7:0] pwm_pin;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] pol_m = '0;

  pwm_pol_stage u_pwm_pol_stage (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .wp_dis(wp_dis),
    .fault_ctl_en(fault_ctl_en), .fault_det(fault_det),
    .pwm_raw(pwm_raw), .pwm_pin(pwm_pin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] d, logic wp);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d; wp_dis = wp;
    @(negedge clk);
    reg_wr = 1'b0;
    if (wp) pol_m = d;
  endtask

  task automatic do_read(string tag);
    @(negedge clk);
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    #1;
    check8(tag, reg_rdata, pol_m);
  endtask

  function automatic logic [7:0] pin_model(logic [7:0] r, logic [7:0] p,
                                           logic en, logic det);
    return (en && det) ? p : (r ^ p);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    pwm_raw = 8'hA5;
    #2;
    check8("R1 pin after reset", pwm_pin, 8'hA5);
    check8("R1 rdata after reset", reg_rdata, 8'h00);
    do_read("R1 read after reset");

    // Protected write is dropped
    do_write(8'h3C, 1'b1);
    do_write(8'hC3, 1'b0);
    pwm_raw = 8'h00; #2;
    check8("R7 pins after blocked write", pwm_pin, 8'h3C);
    wp_dis = 1'b0;
    do_read("R7 R8 read while protected");

    // Release paths
    @(negedge clk);
    pwm_raw = 8'hF0; fault_ctl_en = 1'b1; fault_det = 1'b1; #2;
    check8("R4 force same cycle", pwm_pin, pol_m);
    fault_det = 1'b0; #2;
    check8("R5 release on fault drop", pwm_pin, 8'hF0 ^ pol_m);
    fault_det = 1'b1; #2;
    check8("R4 force again", pwm_pin, pol_m);
    fault_ctl_en = 1'b0; #2;
    check8("R5 release on enable drop", pwm_pin, 8'hF0 ^ pol_m);
    fault_det = 1'b0;

    // Full sweep: every polarity value, every raw pattern, varied fault inputs
    for (int p = 0; p < 256; p++) begin
      do_write(p[7:0], 1'b1);
      check8("R6 write visible at pins next cycle",
             pin_model(pwm_raw, pol_m, 1'b0, 1'b0) ^ pwm_raw ^ pwm_raw,
             pwm_pin);
      for (int r = 0; r < 256; r++) begin
        logic [1:0] fsel;
        fsel = 2'(r * 7 + p);
        @(negedge clk);
        pwm_raw = r[7:0];
        fault_ctl_en = fsel[1];
        fault_det = fsel[0];
        #2;
        if (fsel == 2'b11)
          check8("R4 safe level", pwm_pin,
                 pin_model(r[7:0], pol_m, 1'b1, 1'b1));
        else
          check8("R2 R3 R5 polarity path", pwm_pin,
                 pin_model(r[7:0], pol_m, fsel[1], fsel[0]));
      end
      fault_ctl_en = 1'b0; fault_det = 1'b0;
      if (p % 16 == 0) do_read("R8 read back");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule